// File: doc/BRIEF.md
# Physical Page Directory with Table-Owner Back-Pointers

The block is a set-associative directory of physical pages. Each entry holds a physical tag, a location table that gives every cache line of the page a 2-bit residency code and a cache way number, a valid bit, and a back-pointer to the translation entry that holds the active copy of that table. A back-valid flag says whether that back-pointer is in force. A lookup with a physical page number returns the entry's location table.

On a miss the directory picks a victim way and cleans up the victim page. It walks the victim's location table one line at a time and sends an eviction command for each line held in the first-level or second-level cache. It then invalidates the owning translation entry, if there is one, and installs the new page with every line marked as not cached. The cache arrays and the translation buffer are outside the block. They are reached through command ports: the eviction port has an acknowledge, and the invalidation port is a one-cycle pulse. Side ports record a translation fill, take a table written back by the translation buffer, and apply a notice that the second-level cache dropped a line.

The cleanup is run by a state machine with these states:
- IDLE: ready for a lookup. A miss goes to SELECT.
- SELECT: the victim way is fixed. An occupied victim goes to WALK; a free way goes straight to INSTALL.
- WALK: one line slot is handled per cycle. A slot with code 0 moves on at once. Any other code holds its eviction command until it is acknowledged. The last slot goes to INVAL.
- INVAL: the owner invalidation is issued, then INSTALL.
- INSTALL: the entry is written, then DONE.
- DONE: the miss response is produced, then IDLE.

Top module: `page_directory`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `ev_valid` and `inv_valid` are 0. Every entry is invalid, so the first lookup of any page misses.
- R2: A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The set is `req_ppn[SET_BITS-1:0]` and the tag is the bits above it. A hit is a valid entry in that set whose tag matches. On a hit, `rsp_valid` is 1 in the cycle after acceptance, with `rsp_hit`=1, the matching way in `rsp_way`, and the entry's tables in `rsp_loc` and `rsp_cway`. Line i of `rsp_loc` is at bits [2i+1:2i], and its cache way is at [CWAY_W*i +: CWAY_W].
- R3: A miss chooses the lowest-numbered invalid way of the set. If the set has no invalid way, it chooses the way with the smallest access stamp, and a tie goes to the lowest way. Each hit, and each install, writes the value of a global access counter into the entry's stamp and then increments the counter.
- R4: When the victim is valid, its line slots are walked in ascending order. Code 0 (not cached) is skipped. Codes 1 and 2 (first-level cache) issue `ev_level`=0. Code 3 (second-level cache) issues `ev_level`=1. Each command carries the stored way in `ev_way` and the slot in `ev_line`, and `ev_valid` stays high with the same fields until `ev_ack` is 1 at a clock edge.
- R5: After the walk, if the victim's back-valid flag is set, `inv_valid` pulses for one cycle. `inv_set` is the back-pointer modulo 2^PTR_SET_BITS, and `inv_way` is the back-pointer shifted right by PTR_SET_BITS. If the flag is clear, there is no pulse. When a free way is chosen, there is neither a walk nor a pulse.
- R6: An install stores the tag and sets the valid bit. It clears every location code, every way number and the back-valid flag. The miss response has `rsp_hit`=0, the chosen way in `rsp_way`, and all-zero tables.
- R7: A pulse on `fill_valid` stores `fill_ptr` as the back-pointer of the entry (`fill_set`, `fill_way`) and sets that entry's back-valid flag.
- R8: A pulse on `wb_valid` replaces the tables of the entry (`wb_set`, `wb_way`) with `wb_loc` and `wb_cway`, and clears that entry's back-valid flag.
- R9: A pulse on `l2ev_valid` names an entry and a line. If that entry's back-valid flag is set, `fix_valid` is 1 in the same cycle, with that entry's back-pointer on `fix_ptr` and the line on `fix_line`, and the directory's own table is left unchanged. If the flag is clear, the line's code in the directory's own table becomes 0.
- R10: `req_ready` is 0 from the edge that accepts a missing lookup until the edge that raises the miss response. `req_ready` returns to 1 in the same cycle as that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted |
| req_ppn | input | TAG_W+SET_BITS | Physical page number |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 on hit, 0 on fresh install |
| rsp_way | output | log2(WAYS) | Directory way of the entry |
| rsp_loc | output | 2*LINES | Location codes per line |
| rsp_cway | output | CWAY_W*LINES | Cache way per line |
| ev_valid | output | 1 | Eviction command |
| ev_level | output | 1 | 0 first level, 1 second level |
| ev_way | output | CWAY_W | Cache way to evict |
| ev_line | output | log2(LINES) | Line slot within the page |
| ev_ack | input | 1 | Eviction accepted |
| inv_valid | output | 1 | Translation entry invalidate pulse |
| inv_set | output | PTR_SET_BITS | Translation set |
| inv_way | output | PTR_W-PTR_SET_BITS | Translation way |
| fill_valid | input | 1 | Translation fill done |
| fill_set | input | SET_BITS | Directory set of the fill |
| fill_way | input | log2(WAYS) | Directory way of the fill |
| fill_ptr | input | PTR_W | Translation entry pointer |
| wb_valid | input | 1 | Table write-back |
| wb_set | input | SET_BITS | Directory set |
| wb_way | input | log2(WAYS) | Directory way |
| wb_loc | input | 2*LINES | Location codes |
| wb_cway | input | CWAY_W*LINES | Cache ways |
| l2ev_valid | input | 1 | Second-level line dropped |
| l2ev_set | input | SET_BITS | Directory set |
| l2ev_way | input | log2(WAYS) | Directory way |
| l2ev_line | input | log2(LINES) | Line slot |
| fix_valid | output | 1 | Forward code clear to translation copy |
| fix_ptr | output | PTR_W | Owning translation entry |
| fix_line | output | log2(LINES) | Line slot to clear |

## Verification
A hit response is due in the cycle right after the accepting edge, so the bench samples it at the next falling edge. A miss has no fixed latency: it takes three cycles for a free way and, for an occupied way, one more cycle per line plus the acknowledge delays and the invalidation cycle. The bench therefore services the command ports on every falling edge, with random acknowledge delays, until the response appears. It checks each eviction command against the slot order worked out from its own model of the victim's table, and it checks that `req_ready` stays low for the whole walk. The `fix_*` outputs follow the notice in the same cycle and are sampled just after it is driven.

// File: rtl/page_directory_pkg.sv
package page_directory_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_SELECT,
        WS_WALK,
        WS_INVAL,
        WS_INSTALL,
        WS_DONE
    } walk_state_e;

    localparam logic [1:0] LOC_NONE = 2'd0;
    localparam logic [1:0] LOC_L1I  = 2'd1;
    localparam logic [1:0] LOC_L1D  = 2'd2;
    localparam logic [1:0] LOC_L2   = 2'd3;

endpackage

// File: rtl/pgdir_match.sv
module pgdir_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]      probe,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == probe);
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/pgdir_victim.sv
module pgdir_victim #(
    parameter int WAYS    = 4,
    parameter int STAMP_W = 12,
    parameter int WAY_W   = 2
) (
    input  logic [WAYS-1:0]         way_valid,
    input  logic [WAYS*STAMP_W-1:0] way_stamps,
    output logic [WAY_W-1:0]        pick
);
    logic               have_free;
    logic [WAY_W-1:0]   free_way;
    logic [WAY_W-1:0]   lru_way;
    logic [STAMP_W-1:0] best;

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end
    end

    always_comb begin
        lru_way = '0;
        best    = way_stamps[0 +: STAMP_W];
        for (int w = 1; w < WAYS; w++) begin
            if (way_stamps[w*STAMP_W +: STAMP_W] < best) begin
                best    = way_stamps[w*STAMP_W +: STAMP_W];
                lru_way = WAY_W'(w);
            end
        end
    end

    assign pick = have_free ? free_way : lru_way;
endmodule

// File: rtl/pgdir_walker.sv
module pgdir_walker
    import page_directory_pkg::*;
#(
    parameter int LINES        = 8,
    parameter int LINE_W       = 3,
    parameter int CWAY_W       = 2,
    parameter int WAY_W        = 2,
    parameter int PTR_W        = 5,
    parameter int PTR_SET_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [WAY_W-1:0]          pick_way,
    input  logic                      vic_valid,
    input  logic [2*LINES-1:0]        vic_loc,
    input  logic [CWAY_W*LINES-1:0]   vic_cway,
    input  logic                      vic_bv,
    input  logic [PTR_W-1:0]          vic_ptr,
    input  logic                      ev_ack,
    output logic                      busy,
    output logic [WAY_W-1:0]          vway,
    output logic                      ev_valid,
    output logic                      ev_level,
    output logic [CWAY_W-1:0]         ev_way,
    output logic [LINE_W-1:0]         ev_line,
    output logic                      inv_valid,
    output logic [PTR_SET_BITS-1:0]   inv_set,
    output logic [PTR_W-PTR_SET_BITS-1:0] inv_way,
    output logic                      install,
    output logic                      done
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    walk_state_e      state_q, state_d;
    logic [LINE_W-1:0] idx_q, idx_d;
    logic [WAY_W-1:0]  vway_q, vway_d;
    logic [1:0]        code;

    assign code = vic_loc[2*idx_q +: 2];
    assign vway = (state_q == WS_SELECT) ? pick_way : vway_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            idx_q   <= '0;
            vway_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            vway_q  <= vway_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        vway_d  = vway_q;
        unique case (state_q)
            WS_IDLE: begin
                if (start) state_d = WS_SELECT;
            end
            WS_SELECT: begin
                vway_d  = pick_way;
                idx_d   = '0;
                state_d = vic_valid ? WS_WALK : WS_INSTALL;
            end
            WS_WALK: begin
                if (code == LOC_NONE || ev_ack) begin
                    if (idx_q == LAST_LINE) state_d = WS_INVAL;
                    else                    idx_d   = idx_q + 1'b1;
                end
            end
            WS_INVAL:   state_d = WS_INSTALL;
            WS_INSTALL: state_d = WS_DONE;
            WS_DONE:    state_d = WS_IDLE;
            default:    state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != WS_IDLE);
        ev_valid  = 1'b0;
        ev_level  = 1'b0;
        ev_way    = vic_cway[CWAY_W*idx_q +: CWAY_W];
        ev_line   = idx_q;
        inv_valid = 1'b0;
        inv_set   = vic_ptr[PTR_SET_BITS-1:0];
        inv_way   = vic_ptr[PTR_W-1:PTR_SET_BITS];
        install   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            WS_WALK: begin
                ev_valid = (code != LOC_NONE);
                ev_level = (code == LOC_L2);
            end
            WS_INVAL:   inv_valid = vic_bv;
            WS_INSTALL: install   = 1'b1;
            WS_DONE:    done      = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/page_directory.sv
module page_directory #(
    parameter int SET_BITS     = 2,
    parameter int WAYS         = 4,
    parameter int TAG_W        = 6,
    parameter int LINES        = 8,
    parameter int CWAY_W       = 2,
    parameter int PTR_SET_BITS = 2,
    parameter int PTR_W        = 5,
    parameter int STAMP_W      = 12,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINE_W = $clog2(LINES),
    localparam int PPN_W  = TAG_W + SET_BITS,
    localparam int LOC_W  = 2 * LINES,
    localparam int CTAB_W = CWAY_W * LINES,
    localparam int TW_W   = PTR_W - PTR_SET_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [PPN_W-1:0]        req_ppn,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [WAY_W-1:0]        rsp_way,
    output logic [LOC_W-1:0]        rsp_loc,
    output logic [CTAB_W-1:0]       rsp_cway,
    output logic                    ev_valid,
    output logic                    ev_level,
    output logic [CWAY_W-1:0]       ev_way,
    output logic [LINE_W-1:0]       ev_line,
    input  logic                    ev_ack,
    output logic                    inv_valid,
    output logic [PTR_SET_BITS-1:0] inv_set,
    output logic [TW_W-1:0]         inv_way,
    input  logic                    fill_valid,
    input  logic [SET_BITS-1:0]     fill_set,
    input  logic [WAY_W-1:0]        fill_way,
    input  logic [PTR_W-1:0]        fill_ptr,
    input  logic                    wb_valid,
    input  logic [SET_BITS-1:0]     wb_set,
    input  logic [WAY_W-1:0]        wb_way,
    input  logic [LOC_W-1:0]        wb_loc,
    input  logic [CTAB_W-1:0]       wb_cway,
    input  logic                    l2ev_valid,
    input  logic [SET_BITS-1:0]     l2ev_set,
    input  logic [WAY_W-1:0]        l2ev_way,
    input  logic [LINE_W-1:0]       l2ev_line,
    output logic                    fix_valid,
    output logic [PTR_W-1:0]        fix_ptr,
    output logic [LINE_W-1:0]       fix_line
);
    localparam int ENT_W   = SET_BITS + WAY_W;
    localparam int ENTRIES = 1 << ENT_W;

    logic               valid_q [ENTRIES];
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [LOC_W-1:0]   loc_q   [ENTRIES];
    logic [CTAB_W-1:0]  cway_q  [ENTRIES];
    logic               bv_q    [ENTRIES];
    logic [PTR_W-1:0]   ptr_q   [ENTRIES];
    logic [STAMP_W-1:0] stamp_q [ENTRIES];
    logic [STAMP_W-1:0] ctr_q;

    logic [SET_BITS-1:0] cur_set_q;
    logic [TAG_W-1:0]    cur_tag_q;

    logic [SET_BITS-1:0] req_set;
    logic [TAG_W-1:0]    req_tag;
    assign req_set = req_ppn[SET_BITS-1:0];
    assign req_tag = req_ppn[PPN_W-1:SET_BITS];

    // per-way views of the requested set and of the set under replacement
    logic [WAYS-1:0]         m_valid;
    logic [WAYS*TAG_W-1:0]   m_tags;
    logic [WAYS-1:0]         v_valid;
    logic [WAYS*STAMP_W-1:0] v_stamps;

    for (genvar w = 0; w < WAYS; w++) begin : g_view
        assign m_valid[w]                    = valid_q[{req_set, WAY_W'(w)}];
        assign m_tags[w*TAG_W +: TAG_W]      = tag_q[{req_set, WAY_W'(w)}];
        assign v_valid[w]                    = valid_q[{cur_set_q, WAY_W'(w)}];
        assign v_stamps[w*STAMP_W +: STAMP_W] = stamp_q[{cur_set_q, WAY_W'(w)}];
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] pick_way;

    pgdir_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_valid (m_valid),
        .way_tags  (m_tags),
        .probe     (req_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    pgdir_victim #(.WAYS(WAYS), .STAMP_W(STAMP_W), .WAY_W(WAY_W)) u_victim (
        .way_valid  (v_valid),
        .way_stamps (v_stamps),
        .pick       (pick_way)
    );

    logic             busy;
    logic             accept;
    logic             start;
    logic [WAY_W-1:0] vway;
    logic             install;
    logic             done;
    logic [ENT_W-1:0] vent;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign start     = accept && !hit;
    assign vent      = {cur_set_q, vway};

    pgdir_walker #(
        .LINES(LINES), .LINE_W(LINE_W), .CWAY_W(CWAY_W), .WAY_W(WAY_W),
        .PTR_W(PTR_W), .PTR_SET_BITS(PTR_SET_BITS)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pick_way  (pick_way),
        .vic_valid (valid_q[vent]),
        .vic_loc   (loc_q[vent]),
        .vic_cway  (cway_q[vent]),
        .vic_bv    (bv_q[vent]),
        .vic_ptr   (ptr_q[vent]),
        .ev_ack    (ev_ack),
        .busy      (busy),
        .vway      (vway),
        .ev_valid  (ev_valid),
        .ev_level  (ev_level),
        .ev_way    (ev_way),
        .ev_line   (ev_line),
        .inv_valid (inv_valid),
        .inv_set   (inv_set),
        .inv_way   (inv_way),
        .install   (install),
        .done      (done)
    );

    // second-level drop notice: forward to owner copy or clear locally
    logic [ENT_W-1:0] l2_ent;
    assign l2_ent    = {l2ev_set, l2ev_way};
    assign fix_valid = l2ev_valid && bv_q[l2_ent];
    assign fix_ptr   = ptr_q[l2_ent];
    assign fix_line  = l2ev_line;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                loc_q[e]   <= '0;
                cway_q[e]  <= '0;
                bv_q[e]    <= 1'b0;
                ptr_q[e]   <= '0;
                stamp_q[e] <= '0;
            end
            ctr_q     <= '0;
            cur_set_q <= '0;
            cur_tag_q <= '0;
        end else begin
            if (fill_valid) begin
                ptr_q[{fill_set, fill_way}] <= fill_ptr;
                bv_q[{fill_set, fill_way}]  <= 1'b1;
            end
            if (wb_valid) begin
                loc_q[{wb_set, wb_way}]  <= wb_loc;
                cway_q[{wb_set, wb_way}] <= wb_cway;
                bv_q[{wb_set, wb_way}]   <= 1'b0;
            end
            if (l2ev_valid && !bv_q[l2_ent]) begin
                loc_q[l2_ent][2*l2ev_line +: 2] <= 2'b00;
            end
            if (accept) begin
                cur_set_q <= req_set;
                cur_tag_q <= req_tag;
                if (hit) begin
                    stamp_q[{req_set, hit_way}] <= ctr_q;
                    ctr_q <= ctr_q + 1'b1;
                end
            end
            if (install) begin
                valid_q[vent] <= 1'b1;
                tag_q[vent]   <= cur_tag_q;
                loc_q[vent]   <= '0;
                cway_q[vent]  <= '0;
                bv_q[vent]    <= 1'b0;
                stamp_q[vent] <= ctr_q;
                ctr_q <= ctr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_loc   <= '0;
            rsp_cway  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && hit) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b1;
                rsp_way   <= hit_way;
                rsp_loc   <= loc_q[{req_set, hit_way}];
                rsp_cway  <= cway_q[{req_set, hit_way}];
            end else if (done) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_way   <= vway;
                rsp_loc   <= '0;
                rsp_cway  <= '0;
            end
        end
    end
endmodule

// File: rtl/page_directory_sva.sv
module page_directory_sva #(
    parameter int CWAY_W = 2,
    parameter int LINE_W = 3,
    parameter int LOC_W  = 16,
    parameter int CTAB_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [LOC_W-1:0]  rsp_loc,
    input logic [CTAB_W-1:0] rsp_cway,
    input logic              ev_valid,
    input logic              ev_level,
    input logic [CWAY_W-1:0] ev_way,
    input logic [LINE_W-1:0] ev_line,
    input logic              ev_ack,
    input logic              inv_valid,
    input logic              l2ev_valid,
    input logic              fix_valid
);
    a_r4_ev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ack |=> ev_valid && $stable(ev_way) && $stable(ev_line) && $stable(ev_level));

    a_r4_line_order: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_ack |=> !ev_valid || (ev_line > $past(ev_line)));

    a_r5_inv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);

    a_r10_busy_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid || inv_valid) |-> !req_ready);

    a_r10_ready_return: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> rsp_valid && !rsp_hit);

    a_r6_install_blank: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> (rsp_loc == '0) && (rsp_cway == '0));

    a_r9_fix_needs_notice: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> l2ev_valid);
endmodule

bind page_directory page_directory_sva #(
    .CWAY_W(CWAY_W), .LINE_W(LINE_W), .LOC_W(LOC_W), .CTAB_W(CTAB_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_loc(rsp_loc), .rsp_cway(rsp_cway),
    .ev_valid(ev_valid), .ev_level(ev_level), .ev_way(ev_way), .ev_line(ev_line),
    .ev_ack(ev_ack), .inv_valid(inv_valid), .l2ev_valid(l2ev_valid),
    .fix_valid(fix_valid)
);

// File: tb/page_directory_tb.sv
`timescale 1ns/1ps
module page_directory_tb;
    localparam int SB = 2, WAYS = 4, TW = 6, LINES = 8, CW = 2, PSB = 2, PW = 5;
    localparam int WW = 2, LW = 3, NENT = 16;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic req_valid = 0, ev_ack = 0, fill_valid = 0, wb_valid = 0, l2ev_valid = 0;
    logic [TW+SB-1:0] req_ppn = 0;
    logic [SB-1:0] fill_set = 0, wb_set = 0, l2ev_set = 0;
    logic [WW-1:0] fill_way = 0, wb_way = 0, l2ev_way = 0;
    logic [PW-1:0] fill_ptr = 0;
    logic [2*LINES-1:0] wb_loc = 0;
    logic [CW*LINES-1:0] wb_cway = 0;
    logic [LW-1:0] l2ev_line = 0;
    logic req_ready, rsp_valid, rsp_hit, ev_valid, ev_level, inv_valid, fix_valid;
    logic [WW-1:0] rsp_way;
    logic [2*LINES-1:0] rsp_loc;
    logic [CW*LINES-1:0] rsp_cway;
    logic [CW-1:0] ev_way;
    logic [LW-1:0] ev_line, fix_line;
    logic [PSB-1:0] inv_set;
    logic [PW-PSB-1:0] inv_way;
    logic [PW-1:0] fix_ptr;

    page_directory u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit ended = 0;

    // bench model
    bit                 m_val [NENT];
    logic [TW-1:0]      m_tag [NENT];
    logic [2*LINES-1:0] m_loc [NENT];
    logic [CW*LINES-1:0] m_cw [NENT];
    bit                 m_bv  [NENT];
    logic [PW-1:0]      m_ptr [NENT];
    int                 m_stamp [NENT];
    int                 m_ctr = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int pick_victim(input int s);
        for (int w = 0; w < WAYS; w++) if (!m_val[s*WAYS+w]) return w;
        begin
            int best = 0;
            for (int w = 1; w < WAYS; w++)
                if (m_stamp[s*WAYS+w] < m_stamp[s*WAYS+best]) best = w;
            return best;
        end
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic lookup(input logic [TW+SB-1:0] ppn);
        int s, t, hw, vw, e, k, wt, guard, ninv;
        bit hitm, rdy_bad;
        s = int'(ppn[SB-1:0]); t = int'(ppn[TW+SB-1:SB]);
        hitm = 0; hw = 0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_val[s*WAYS+w] && m_tag[s*WAYS+w] == t) begin hitm = 1; hw = w; end
        @(negedge clk); req_valid = 1; req_ppn = ppn;
        @(negedge clk); req_valid = 0;
        if (hitm) begin
            e = s*WAYS+hw;
            chk("R2 rsp_valid on hit", rsp_valid, 1);
            chk("R2 rsp_hit", rsp_hit, 1);
            chk("R2 rsp_way", rsp_way, hw);
            chk("R2/R8/R9 rsp_loc", rsp_loc, m_loc[e]);
            chk("R2/R8 rsp_cway", rsp_cway, m_cw[e]);
            m_stamp[e] = m_ctr; m_ctr++;
            return;
        end
        vw = pick_victim(s); e = s*WAYS+vw;
        k = 0; wt = $urandom % 3; guard = 0; ninv = 0; rdy_bad = 0;
        while (!rsp_valid && guard < 400) begin
            ev_ack = 0;
            if (req_ready) rdy_bad = 1;
            if (ev_valid) begin
                if (wt == 0) begin
                    while (k < LINES && m_loc[e][2*k +: 2] == 2'd0) k++;
                    chk("R4 ev_line order", ev_line, k);
                    chk("R4 ev_level", ev_level, (m_loc[e][2*k +: 2] == 2'd3));
                    chk("R4 ev_way", ev_way, m_cw[e][CW*k +: CW]);
                    k++; ev_ack = 1; wt = $urandom % 3;
                end else wt--;
            end
            if (inv_valid) begin
                ninv++;
                chk("R5 inv_set", inv_set, m_ptr[e][PSB-1:0]);
                chk("R5 inv_way", inv_way, m_ptr[e][PW-1:PSB]);
            end
            @(negedge clk); guard++;
        end
        ev_ack = 0;
        while (k < LINES && m_loc[e][2*k +: 2] == 2'd0) k++;
        chk("R4 all cached lines evicted", (m_val[e] ? k : LINES), LINES);
        chk("R5 inv count", ninv, (m_val[e] && m_bv[e]) ? 1 : 0);
        chk("R10 req_ready low during miss", rdy_bad, 0);
        chk("R10 req_ready back with response", req_ready, 1);
        chk("R6 miss rsp_valid", rsp_valid, 1);
        chk("R6 miss rsp_hit", rsp_hit, 0);
        chk("R3 victim way", rsp_way, vw);
        chk("R6 miss tables", {rsp_loc, rsp_cway}, 0);
        m_val[e] = 1; m_tag[e] = t; m_loc[e] = 0; m_cw[e] = 0; m_bv[e] = 0;
        m_stamp[e] = m_ctr; m_ctr++;
    endtask

    task automatic do_fill(input int s, input int w, input logic [PW-1:0] p);
        @(negedge clk); fill_valid = 1; fill_set = SB'(s); fill_way = WW'(w); fill_ptr = p;
        @(negedge clk); fill_valid = 0;
        m_ptr[s*WAYS+w] = p; m_bv[s*WAYS+w] = 1;
    endtask

    task automatic do_wb(input int s, input int w, input logic [2*LINES-1:0] l,
                         input logic [CW*LINES-1:0] c);
        @(negedge clk); wb_valid = 1; wb_set = SB'(s); wb_way = WW'(w); wb_loc = l; wb_cway = c;
        @(negedge clk); wb_valid = 0;
        m_loc[s*WAYS+w] = l; m_cw[s*WAYS+w] = c; m_bv[s*WAYS+w] = 0;
    endtask

    task automatic do_l2(input int s, input int w, input int ln);
        int e;
        e = s*WAYS+w;
        @(negedge clk); l2ev_valid = 1; l2ev_set = SB'(s); l2ev_way = WW'(w); l2ev_line = LW'(ln);
        #1;
        chk("R9 fix_valid", fix_valid, m_bv[e]);
        if (m_bv[e]) begin
            chk("R9 fix_ptr", fix_ptr, m_ptr[e]);
            chk("R9 fix_line", fix_line, ln);
        end else m_loc[e][2*ln +: 2] = 2'd0;
        @(negedge clk); l2ev_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681));
        for (int e = 0; e < NENT; e++) begin
            m_val[e] = 0; m_tag[e] = 0; m_loc[e] = 0; m_cw[e] = 0;
            m_bv[e] = 0; m_ptr[e] = 0; m_stamp[e] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 req_ready after reset", req_ready, 1);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 ev_valid after reset", ev_valid, 0);
        chk("R1 inv_valid after reset", inv_valid, 0);

        // directed: fill set 1 (R1 first miss, R3 free ways in order, R5 no walk)
        for (int i = 0; i < WAYS; i++) lookup({TW'(i + 1), SB'(1)});
        lookup({TW'(2), SB'(1)});                                 // hit, R2
        do_wb(1, 0, 16'hE4E4, 16'h1B6C);                            // R8, all codes
        do_fill(1, 0, 5'b10110);                                    // R7
        do_l2(1, 0, 3);                                             // R9 forward
        do_wb(1, 1, 16'hFFFF, 16'hFFFF);
        do_l2(1, 1, 2);                                             // R9 local clear
        lookup({TW'(2), SB'(1)});                                   // sees cleared code
        do_wb(1, 2, 16'h0000, 16'h0000);
        lookup({TW'(9), SB'(1)});   // victim way 0: walk + invalidate (R4, R5)
        lookup({TW'(10), SB'(1)});  // victim way 2 (oldest): empty walk, no inval

        for (int it = 0; it < 350; it++) begin
            int op, s, w;
            op = $urandom % 10; s = $urandom % 4; w = $urandom % WAYS;
            if (op < 5 || !m_val[s*WAYS+w]) lookup({TW'($urandom % 8), SB'(s)});
            else if (op < 7) do_wb(s, w, 16'($urandom), 16'($urandom));
            else if (op < 8) do_fill(s, w, 5'($urandom));
            else do_l2(s, w, $urandom % LINES);
        end
        finish_run();
    end
endmodule